// File: doc/BRIEF.md
# Word-Sequence Trigger Recognizer

This block is the trigger stage of a logic-analyzer style capture path. It watches a 32-bit sampled data bus, qualified by a sample-valid strobe, and raises a trigger flag once a programmed condition on the stream of words has been seen. Three compare words are programmed, each with its own care mask. Words A and B drive the recognition modes, and word C acts as a restart word. The modes are: A seen N times, A immediately followed by B, and A immediately followed by something other than B. A match on C clears all recognition progress.

The recognizer only evaluates samples while it is armed. The trigger is sticky. A new rising edge on the arm input clears it and starts recognition again from the beginning. Sample storage and clock generation belong to the surrounding capture logic.

Top module: `seqtrig_unit`

## Requirements
- R1: A sample matches a compare word when every bit whose mask bit is 1 equals the word's bit. Mask bits of 0 are don't care.
- R2: With cfg_mode = 0, trig is raised by the N-th valid armed sample that matches A. Samples that do not match A are not counted but also do not clear the count. The count runs from arming or from the last C reset. N is cfg_count, and a value of 0 is treated as 1.
- R3: With cfg_mode = 1, trig is raised by a valid sample that matches B when the previous valid sample matched A. A non-B sample after A returns to waiting for A, unless that sample itself matches A.
- R4: With cfg_mode = 2, trig is raised by the first valid sample after an A match that does not match B. If that sample matches B, the recognizer returns to waiting for A.
- R5: With cfg_mode = 3, trig is never raised.
- R6: When cfg_c_en = 1, a valid armed sample matching C returns the recognizer to its initial state and clears the occurrence count. This takes priority over any A or B match on the same sample. When cfg_c_en = 0, C has no effect.
- R7: trig rises on the clock edge that captures the completing sample. It then stays high, whatever is sampled and whatever the arm level, until the next re-arm.
- R8: A re-arm is a cycle with arm high whose previous cycle had arm low. It clears trig, the count and the sequence state. The sample presented in that cycle is not evaluated.
- R9: While arm is low, or smp_valid is low, samples have no effect on trig or on the recognition progress.
- R10: After reset, trig is low and the recognizer waits for A with a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 count A, 1 A then B, 2 A then not B, 3 off |
| cfg_count | input | 8 | Occurrence target N for mode 0 (0 acts as 1) |
| cfg_c_en | input | 1 | Enables the restart word C |
| word_a | input | 32 | Compare word A |
| mask_a | input | 32 | Care mask for A (1 = compare) |
| word_b | input | 32 | Compare word B |
| mask_b | input | 32 | Care mask for B |
| word_c | input | 32 | Restart word C |
| mask_c | input | 32 | Care mask for C |
| arm | input | 1 | Arm level; a rising edge re-arms |
| smp_valid | input | 1 | Qualifies smp_data this cycle |
| smp_data | input | 32 | Sampled bus word |
| trig | output | 1 | Sticky trigger flag |

## Verification
The bench targets the cases where sequence logic tends to slip. An unrelated word between A and B must break the pair. If it did not, the design would trigger late on a stale A. A gap of invalid samples must not count as a "next" sample. A C word that also matches A must win, or the design would fire on a word meant to clear it. An N of zero must act as one, or the design would wait for 256 matches. Masked bits of B must be ignored. Once raised, trig must survive disarming and later samples, and it must drop only on a fresh rising edge of arm.

// File: rtl/seqtrig_pkg.sv
package seqtrig_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int NWORDS = 3;

    localparam int IDX_A = 0;
    localparam int IDX_B = 1;
    localparam int IDX_C = 2;

    typedef enum logic [1:0] {
        MODE_COUNT     = 2'd0,
        MODE_FOLLOW    = 2'd1,
        MODE_NOTFOLLOW = 2'd2,
        MODE_OFF       = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_WAIT_A = 2'd0,
        ST_SAW_A  = 2'd1,
        ST_FIRED  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/seqtrig_word_match.sv
module seqtrig_word_match #(
    parameter int W = 32
) (
    input  logic [W-1:0] smp,
    input  logic [W-1:0] pattern,
    input  logic [W-1:0] care,
    output logic         hit
);
    logic [W-1:0] diff;

    always_comb begin
        diff = (smp ^ pattern) & care;
        hit  = (diff == '0);
    end
endmodule

// File: rtl/seqtrig_occ_count.sv
module seqtrig_occ_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    output logic             reach
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } occ_s;

    occ_s st_d, st_q;
    logic [CNT_W:0]   bumped;
    logic [CNT_W-1:0] eff_target;

    always_comb begin
        st_d       = st_q;
        eff_target = (target == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : target;
        bumped     = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        reach      = inc && (bumped >= {1'b0, eff_target});
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = bumped[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/seqtrig_unit.sv
module seqtrig_unit
    import seqtrig_pkg::*;
#(
    parameter int DATA_W = seqtrig_pkg::DATA_W,
    parameter int CNT_W  = seqtrig_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_c_en,
    input  logic [DATA_W-1:0] word_a,
    input  logic [DATA_W-1:0] mask_a,
    input  logic [DATA_W-1:0] word_b,
    input  logic [DATA_W-1:0] mask_b,
    input  logic [DATA_W-1:0] word_c,
    input  logic [DATA_W-1:0] mask_c,
    input  logic              arm,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              trig
);

    typedef struct packed {
        seq_state_e state;
        logic       trig;
        logic       arm_prev;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [NWORDS-1:0][DATA_W-1:0] pat_vec;
    logic [NWORDS-1:0][DATA_W-1:0] care_vec;
    logic [NWORDS-1:0]             hit_vec;

    logic       arm_rise;
    logic       take;
    logic       c_reset;
    logic       cnt_clr;
    logic       cnt_inc;
    logic       cnt_reach;
    trig_mode_e mode;

    always_comb begin
        pat_vec[IDX_A]  = word_a;
        pat_vec[IDX_B]  = word_b;
        pat_vec[IDX_C]  = word_c;
        care_vec[IDX_A] = mask_a;
        care_vec[IDX_B] = mask_b;
        care_vec[IDX_C] = mask_c;
    end

    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_match
        seqtrig_word_match #(.W(DATA_W)) match_i (
            .smp     (smp_data),
            .pattern (pat_vec[gi]),
            .care    (care_vec[gi]),
            .hit     (hit_vec[gi])
        );
    end

    seqtrig_occ_count #(.CNT_W(CNT_W)) occ_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .target (cfg_count),
        .reach  (cnt_reach)
    );

    always_comb begin
        mode     = trig_mode_e'(cfg_mode);
        arm_rise = arm && !ctl_q.arm_prev;
        take     = arm && !arm_rise && smp_valid && (ctl_q.state != ST_FIRED);
        c_reset  = take && cfg_c_en && hit_vec[IDX_C];
        cnt_clr  = arm_rise || c_reset;
        cnt_inc  = take && !c_reset && (mode == MODE_COUNT) && hit_vec[IDX_A];

        ctl_d          = ctl_q;
        ctl_d.arm_prev = arm;

        if (arm_rise) begin
            ctl_d.state = ST_WAIT_A;
            ctl_d.trig  = 1'b0;
        end else if (c_reset) begin
            ctl_d.state = ST_WAIT_A;
        end else if (take) begin
            unique case (mode)
                MODE_COUNT: begin
                    if (cnt_reach) begin
                        ctl_d.state = ST_FIRED;
                        ctl_d.trig  = 1'b1;
                    end
                end
                MODE_FOLLOW: begin
                    if (ctl_q.state == ST_SAW_A) begin
                        if (hit_vec[IDX_B]) begin
                            ctl_d.state = ST_FIRED;
                            ctl_d.trig  = 1'b1;
                        end else if (hit_vec[IDX_A]) begin
                            ctl_d.state = ST_SAW_A;
                        end else begin
                            ctl_d.state = ST_WAIT_A;
                        end
                    end else if (hit_vec[IDX_A]) begin
                        ctl_d.state = ST_SAW_A;
                    end
                end
                MODE_NOTFOLLOW: begin
                    if (ctl_q.state == ST_SAW_A) begin
                        if (!hit_vec[IDX_B]) begin
                            ctl_d.state = ST_FIRED;
                            ctl_d.trig  = 1'b1;
                        end else begin
                            ctl_d.state = ST_WAIT_A;
                        end
                    end else if (hit_vec[IDX_A]) begin
                        ctl_d.state = ST_SAW_A;
                    end
                end
                default: begin
                    ctl_d.state = ST_WAIT_A;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state    <= ST_WAIT_A;
            ctl_q.trig     <= 1'b0;
            ctl_q.arm_prev <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign trig = ctl_q.trig;

endmodule

// File: rtl/seqtrig_unit_chk.sv
module seqtrig_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic              cfg_c_en,
    input logic [DATA_W-1:0] word_c,
    input logic [DATA_W-1:0] mask_c,
    input logic              arm,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic              trig
);
    logic c_seen;
    assign c_seen = cfg_c_en && (((smp_data ^ word_c) & mask_c) == '0);

    // R7
    sticky_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !$rose(arm)) |=> trig);

    // R8
    rearm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |=> !trig);

    // R9
    disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm && !trig) |=> !trig);

    // R9
    idle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !trig) |=> !trig);

    // R6
    c_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && smp_valid && c_seen && !trig) |=> !trig);

    // R5
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'd3) && !trig) |=> !trig);

endmodule

bind seqtrig_unit seqtrig_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/seqtrig_unit_tb_top.sv
module seqtrig_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] WA = 32'hA5A5_0001;
    localparam logic [31:0] WB = 32'h1234_BEEF;
    localparam logic [31:0] WC = 32'hCCCC_CCCC;
    localparam logic [31:0] WX = 32'h0000_0000;
    localparam logic [31:0] WBM = 32'hFFFF_BEEF;

    // row: {rearm, valid, mode[1:0], n[7:0], data[31:0], exp}
    localparam int NROWS = 35;
    localparam logic [44:0] VEC [NROWS] = '{
        {1'b1, 1'b1, 2'd0, 8'd3, WA, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd3, WX, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd3, WA, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd3, WA, 1'b1},
        {1'b0, 1'b1, 2'd0, 8'd3, WX, 1'b1},
        {1'b1, 1'b1, 2'd0, 8'd0, WA, 1'b1},
        {1'b1, 1'b1, 2'd0, 8'd2, WA, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd2, WC, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd2, WA, 1'b0},
        {1'b0, 1'b0, 2'd0, 8'd2, WA, 1'b0},
        {1'b0, 1'b1, 2'd0, 8'd2, WA, 1'b1},
        {1'b1, 1'b1, 2'd1, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WB, 1'b1},
        {1'b1, 1'b1, 2'd1, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WX, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WB, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WA, 1'b0},
        {1'b0, 1'b0, 2'd1, 8'd1, WX, 1'b0},
        {1'b0, 1'b1, 2'd1, 8'd1, WBM, 1'b1},
        {1'b1, 1'b1, 2'd2, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WB, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WX, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WA, 1'b0},
        {1'b0, 1'b0, 2'd2, 8'd1, WX, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WX, 1'b1},
        {1'b1, 1'b1, 2'd2, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WC, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WX, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd2, 8'd1, WA, 1'b1},
        {1'b1, 1'b1, 2'd3, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd3, 8'd1, WB, 1'b0},
        {1'b0, 1'b1, 2'd3, 8'd1, WA, 1'b0},
        {1'b0, 1'b1, 2'd3, 8'd1, WX, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic [7:0]  cfg_count = 8'd1;
    logic        cfg_c_en = 1'b1;
    logic [31:0] word_a = WA;
    logic [31:0] mask_a = 32'hFFFF_FFFF;
    logic [31:0] word_b = WB;
    logic [31:0] mask_b = 32'h0000_FFFF;
    logic [31:0] word_c = WC;
    logic [31:0] mask_c = 32'hFFFF_FFFF;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        trig;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seqtrig_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .cfg_count (cfg_count),
        .cfg_c_en  (cfg_c_en),
        .word_a    (word_a),
        .mask_a    (mask_a),
        .word_b    (word_b),
        .mask_b    (mask_b),
        .word_c    (word_c),
        .mask_c    (mask_c),
        .arm       (arm),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .trig      (trig)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: trig=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rearm();
        @(negedge clk);
        arm = 1'b0;
        smp_valid = 1'b0;
        @(negedge clk);
        arm = 1'b1;
        @(negedge clk);
    endtask

    task automatic sample(input logic v, input logic [31:0] d);
        smp_valid = v;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset", trig, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            string tag;
            cfg_mode  = VEC[i][42:41];
            cfg_count = VEC[i][40:33];
            if (VEC[i][44]) rearm();
            sample(VEC[i][43], VEC[i][32:1]);
            case (VEC[i][42:41])
                2'd0:    tag = "R2 count";
                2'd1:    tag = "R1 R3 follow";
                2'd2:    tag = "R4 notfollow";
                default: tag = "R5 off";
            endcase
            check(tag, trig, VEC[i][0]);
        end

        // R9: disarmed samples are ignored
        cfg_mode = 2'd0;
        cfg_count = 8'd1;
        rearm();
        arm = 1'b0;
        sample(1'b1, WA);
        sample(1'b1, WA);
        check("R9 disarmed", trig, 1'b0);

        // R6: C wins over A on the same sample
        word_c = WA;
        rearm();
        sample(1'b1, WA);
        check("R6 priority", trig, 1'b0);
        word_c = WC;
        sample(1'b1, WA);
        check("R6 after", trig, 1'b1);

        // R8: re-arm clears and ignores its own sample
        @(negedge clk);
        arm = 1'b0;
        @(negedge clk);
        arm = 1'b1;
        smp_valid = 1'b1;
        smp_data = WA;
        @(negedge clk);
        smp_valid = 1'b0;
        check("R8 rearm", trig, 1'b0);

        // R6: C disabled has no effect
        cfg_c_en = 1'b0;
        cfg_mode = 2'd2;
        rearm();
        sample(1'b1, WA);
        sample(1'b1, WC);
        check("R6 c disabled", trig, 1'b1);
        cfg_c_en = 1'b1;

        // R7: sticky through disarm and later samples
        arm = 1'b0;
        sample(1'b1, WX);
        sample(1'b1, WB);
        check("R7 sticky", trig, 1'b1);

        // R8: rising arm alone clears
        rearm();
        check("R8 clear", trig, 1'b0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                nchk++;
                nbad++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule